// File: doc/BRIEF.md
# Serial Control Word Receiver with Frame-Aligned Update

This block takes 16-bit control words from a three-wire serial link (bit clock, data, latch strobe) and turns them into three 14-bit settings: a left volume, a right volume and a control word. Every serial input is brought into the system clock domain through a synchronizer and oversampled there, so the serial clock must run well below the system clock. Bits shift in MSB first on each rising edge of the bit clock, and the rising edge of the latch strobe closes the frame. The bit clock may keep running between frames. Only the 16 bits shifted in just before the latch count.

The two lowest bits of a latched word pick the target register and the upper 14 bits are its new value. A latched value is not applied at once. It is held as pending for its register and only moves to the output on the next edge, rising or falling, of the audio left/right frame clock. This keeps volume and mute changes aligned to sample frames even though the control link runs on its own timing. Each register has its own pending slot, so writes to different registers made before one frame edge all take effect together on that edge.

Top module: `ser_ctl_port`

## Requirements
- R1: On each rising edge of `ser_clk` the current `ser_dat` bit is shifted in MSB first. The frame is the last 16 bits shifted in before the rising edge of `ser_lat`, and any extra bit-clock pulses before those 16 bits are dropped.
- R2: A latched frame changes none of `vol_left`, `vol_right`, `ctrl_word` until an edge of `lr_clk` has been seen. Outputs change only after such an edge.
- R3: Frame bits [1:0] = 00 select left volume. After the next `lr_clk` edge, `vol_left` equals frame bits [15:2].
- R4: Frame bits [1:0] = 01 select right volume. After the next `lr_clk` edge, `vol_right` equals frame bits [15:2].
- R5: Frame bits [1:0] = 10 select the control register. After the next `lr_clk` edge, `ctrl_word` equals frame bits [15:2], and `soft_mute` follows frame bit 11 (bit 9 of `ctrl_word`).
- R6: A frame with bits [1:0] = 11 is dropped. No output changes, including across later `lr_clk` edges.
- R7: Both rising and falling `lr_clk` edges apply pending values. Each register keeps its own pending value. Of several writes to one register before an edge, the last one wins, and writes to different registers all apply on the same edge.
- R8: After reset `vol_left` and `vol_right` are 14'h3FFF (full scale), and `ctrl_word` and `soft_mute` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `ser_clk` and `lr_clk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_lat | input | 1 | Latch strobe; its rising edge ends a frame |
| lr_clk | input | 1 | Audio left/right frame clock; either edge applies pending values |
| vol_left | output | 14 | Left channel volume setting |
| vol_right | output | 14 | Right channel volume setting |
| ctrl_word | output | 14 | Control register setting |
| soft_mute | output | 1 | Soft mute flag taken from the control register |

## Verification
Random 14-bit payloads are sent to random addresses, including the dropped code 11, each with zero to three stray bit-clock pulses before it. A wrong bit order, a miscounted window or a decode mistake would then put the value in the wrong register or shift it. After every latch the outputs are sampled before any frame-clock edge, which catches a register that updates too early. After the edge they are compared to a model. Some rounds send a second frame before the edge, and a directed case sends two writes to one register, so a single shared pending slot or a first-write-wins rule gives a different result. Frame edges alternate between rising and falling, which exposes a design that acts on only one edge direction.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  // Address field width; the address sits in the low bits of every frame.
  localparam int ADDR_W = 2;
  // Number of addressable registers (code 3 is unused).
  localparam int NUM_SLOTS = 3;
  // Frame bit position of the soft mute flag inside a control frame.
  localparam int MUTE_FRAME_BIT = 11;

  typedef enum logic [ADDR_W-1:0] {
    SLOT_LEFT  = 2'b00,
    SLOT_RIGHT = 2'b01,
    SLOT_CTRL  = 2'b10,
    SLOT_NONE  = 2'b11
  } slot_e;

  // True when the address field selects register number idx.
  function automatic logic slot_hit(input logic [ADDR_W-1:0] addr, input int idx);
    return (addr == ADDR_W'(idx)) && (idx < NUM_SLOTS);
  endfunction

  // Volume slots come out of reset at full scale, the control slot at zero.
  function automatic logic resets_full_scale(input int idx);
    return idx != int'(SLOT_CTRL);
  endfunction
endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= (chain_q << 1) | STAGES'(async_in[gi]);
    end
    assign sync_out[gi] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/ser_ctl_shifter.sv
module ser_ctl_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_s,
  input  logic              dat_s,
  input  logic              lat_s,
  output logic              bit_tick,
  output logic              frame_strobe,
  output logic [WORD_W-1:0] frame_word
);
  logic              bclk_q, lat_q;
  logic [WORD_W-1:0] shreg_q;

  assign bit_tick     = bclk_s & ~bclk_q;
  assign frame_strobe = lat_s & ~lat_q;
  assign frame_word   = shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      lat_q   <= 1'b0;
      shreg_q <= '0;
    end else begin
      bclk_q <= bclk_s;
      lat_q  <= lat_s;
      if (bit_tick) shreg_q <= {shreg_q[WORD_W-2:0], dat_s};
    end
  end
endmodule

// File: rtl/ser_ctl_bank.sv
module ser_ctl_bank
  import ser_ctl_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int PW    = WORD_W - ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_strobe,
  input  logic [WORD_W-1:0]     frame_word,
  input  logic                  lr_s,
  output logic                  lr_edge,
  output logic [NUM_SLOTS-1:0]  pend_vec,
  output logic [NUM_SLOTS*PW-1:0] live_flat
);
  logic          lr_q;
  logic [PW-1:0] payload;

  assign lr_edge = lr_s ^ lr_q;
  assign payload = frame_word[WORD_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lr_q <= 1'b0;
    else        lr_q <= lr_s;
  end

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
    localparam logic [PW-1:0] RST_VAL = resets_full_scale(gi) ? {PW{1'b1}} : {PW{1'b0}};
    logic          hit;
    logic          pend_q;
    logic [PW-1:0] stage_q, live_q;

    assign hit = frame_strobe && slot_hit(frame_word[ADDR_W-1:0], gi);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q  <= 1'b0;
        stage_q <= RST_VAL;
        live_q  <= RST_VAL;
      end else begin
        if (hit) stage_q <= payload;
        if (lr_edge && pend_q) live_q <= stage_q;
        if (lr_edge)  pend_q <= hit;
        else if (hit) pend_q <= 1'b1;
      end
    end

    assign pend_vec[gi]            = pend_q;
    assign live_flat[gi*PW +: PW]  = live_q;
  end
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
  import ser_ctl_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = WORD_W - ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_lat,
  input  logic          lr_clk,
  output logic [PW-1:0] vol_left,
  output logic [PW-1:0] vol_right,
  output logic [PW-1:0] ctrl_word,
  output logic          soft_mute
);
  logic [3:0]              sync_lv;
  logic                    bit_tick, frame_strobe, lr_edge;
  logic [WORD_W-1:0]       frame_word;
  logic [NUM_SLOTS-1:0]    pend_vec;
  logic [NUM_SLOTS*PW-1:0] live_flat;

  ser_ctl_sync #(.N(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({lr_clk, ser_lat, ser_dat, ser_clk}),
    .sync_out(sync_lv)
  );

  ser_ctl_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .bclk_s(sync_lv[0]), .dat_s(sync_lv[1]), .lat_s(sync_lv[2]),
    .bit_tick(bit_tick), .frame_strobe(frame_strobe), .frame_word(frame_word)
  );

  ser_ctl_bank #(.WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .frame_strobe(frame_strobe), .frame_word(frame_word),
    .lr_s(sync_lv[3]), .lr_edge(lr_edge),
    .pend_vec(pend_vec), .live_flat(live_flat)
  );

  assign vol_left  = live_flat[int'(SLOT_LEFT)*PW  +: PW];
  assign vol_right = live_flat[int'(SLOT_RIGHT)*PW +: PW];
  assign ctrl_word = live_flat[int'(SLOT_CTRL)*PW  +: PW];
  assign soft_mute = ctrl_word[MUTE_FRAME_BIT-ADDR_W];
endmodule

// File: rtl/ser_ctl_port_chk.sv
module ser_ctl_port_chk
  import ser_ctl_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int PW    = WORD_W - ADDR_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_strobe,
  input logic [WORD_W-1:0]    frame_word,
  input logic                 lr_edge,
  input logic [NUM_SLOTS-1:0] pend_vec,
  input logic [PW-1:0]        vol_left,
  input logic [PW-1:0]        vol_right,
  input logic [PW-1:0]        ctrl_word
);
  p_hold_until_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lr_edge |=> ($stable(vol_left) && $stable(vol_right) && $stable(ctrl_word)));

  p_left_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && frame_word[1:0] == 2'b00) |=> pend_vec[0]);

  p_right_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && frame_word[1:0] == 2'b01) |=> pend_vec[1]);

  p_ctrl_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && frame_word[1:0] == 2'b10) |=> pend_vec[2]);

  p_unused_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && frame_word[1:0] == 2'b11 && !lr_edge) |=> $stable(pend_vec));

  p_edge_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_edge && !frame_strobe) |=> (pend_vec == '0));
endmodule

bind ser_ctl_port ser_ctl_port_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .frame_word(frame_word),
  .lr_edge(lr_edge), .pend_vec(pend_vec),
  .vol_left(vol_left), .vol_right(vol_right), .ctrl_word(ctrl_word)
);

// File: tb/ser_ctl_port_tb_top.sv
`timescale 1ns/1ps
module ser_ctl_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0, lr_clk = 1'b0;
  logic [13:0] vol_left, vol_right, ctrl_word;
  logic soft_mute;
  int checks = 0, errors = 0;

  logic [13:0] exp_live [3];
  logic [13:0] exp_stage[3];
  bit          exp_pend [3];

  always #2.5 clk = ~clk;

  ser_ctl_port dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_lat(ser_lat), .lr_clk(lr_clk), .vol_left(vol_left),
    .vol_right(vol_right), .ctrl_word(ctrl_word), .soft_mute(soft_mute)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] make_frame(input logic [1:0] addr, input logic [13:0] val);
    return (16'(val) << 2) | 16'(addr);
  endfunction

  function automatic logic mute_of(input logic [13:0] ctrl);
    logic [15:0] as_frame = 16'(ctrl) * 16'd4;
    return as_frame[11];
  endfunction

  task automatic send_bit(input logic b);
    ser_dat = b;  wait_clk(4);
    ser_clk = 1'b1; wait_clk(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_frame(input logic [15:0] w, input int junk);
    for (int j = 0; j < junk; j++) send_bit(1'($urandom % 2));
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
    wait_clk(4); ser_lat = 1'b1; wait_clk(4); ser_lat = 1'b0; wait_clk(4);
    if (w[1:0] != 2'b11) begin
      exp_stage[w[1:0]] = w[15:2];
      exp_pend[w[1:0]]  = 1'b1;
    end
  endtask

  task automatic frame_edge();
    lr_clk = ~lr_clk;
    wait_clk(10);
    for (int s = 0; s < 3; s++) if (exp_pend[s]) begin
      exp_live[s] = exp_stage[s];
      exp_pend[s] = 1'b0;
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R3 left"},  16'(vol_left),  16'(exp_live[0]));
    chk({tag, " R4 right"}, 16'(vol_right), 16'(exp_live[1]));
    chk({tag, " R5 ctrl"},  16'(ctrl_word), 16'(exp_live[2]));
    chk({tag, " R5 mute"},  16'(soft_mute), 16'(mute_of(exp_live[2])));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0]  a;
    logic [13:0] v;
    void'($urandom(32'h1d5e_ed07));
    exp_live  = '{14'h3FFF, 14'h3FFF, 14'h0000};
    exp_stage = exp_live;
    exp_pend  = '{0, 0, 0};
    wait_clk(5); rst_n = 1'b1; wait_clk(5);
    // R8: reset values
    chk("R8 left reset",  16'(vol_left),  16'h3FFF);
    chk("R8 right reset", 16'(vol_right), 16'h3FFF);
    chk("R8 ctrl reset",  16'(ctrl_word), 16'h0000);
    chk("R8 mute reset",  16'(soft_mute), 16'h0000);

    // R1: stray bit-clock pulses before the frame are dropped
    send_frame(make_frame(2'b00, 14'h0000), 5);
    check_all("R2 before edge");
    frame_edge();
    check_all("R1 stray bits");

    // R5: control frame with mute bit set (frame bit 11)
    send_frame(16'h0802 | make_frame(2'b10, 14'h0011), 0);
    frame_edge();
    check_all("R5 mute set");

    // R6: unused code leaves everything, across two edges
    send_frame(make_frame(2'b11, 14'h1234), 2);
    frame_edge(); frame_edge();
    check_all("R6 unused code");

    // R7: two writes to one register, last wins, plus another register
    send_frame(make_frame(2'b01, 14'h0AAA), 1);
    send_frame(make_frame(2'b01, 14'h1555), 0);
    send_frame(make_frame(2'b00, 14'h3FFF), 3);
    check_all("R2 still held");
    frame_edge();
    check_all("R7 last wins");

    for (int k = 0; k < 40; k++) begin
      a = 2'($urandom % 4);
      v = 14'($urandom);
      send_frame(make_frame(a, v), int'($urandom % 4));
      if ($urandom % 3 == 0) send_frame(make_frame(2'($urandom % 4), 14'($urandom)), 0);
      wait_clk(10);
      check_all("R2 hold random");
      frame_edge();
      check_all((a == 2'b11) ? "R6 random" : "R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule